// File: doc/BRIEF.md
# Multiplexed-address parallel port read sequencer

This block runs an asynchronous read from an 8-bit external memory, or from a memory-mapped peripheral. The read travels over a 16-bit bus on which address and data share the low byte. The block is clocked by the core clock. All of its bus timing is counted in peripheral clock periods, and each peripheral period is two core cycles.

A core-side request carries a 16-bit address and a configuration: a 5-bit strobe duration, a hold-cycle enable, a flash-mode enable and the ALE polarity. The sequencer then steps through its phases in order. First comes an address phase, in which the whole address is on the bus and ALE is pulsed. A short recovery follows, in which the low byte is released. If flash mode is set, a seven-period wait comes next. Then the read strobe is driven low, and the low byte is captured as the strobe rises. An optional hold period may follow. Last comes a turnaround period, in which the low address byte is driven again.

The captured byte is returned together with a single-cycle done pulse. A request that arrives while a read is under way is ignored. The core issues the next request once done has been seen.

Top module: `pp_rd_seq`

## Requirements
- R1: After reset, and while idle, ale is 0 (its inactive level when active-high ALE is in use), rd_n is 1, ad_oe_lo and ad_oe_hi are 0 and done is 0.
- R2: A request is accepted when req_valid is 1 while the block is idle. ALE is then active for exactly 2 peripheral clocks (4 core cycles). During that time ad_out carries the full address, and both output enables are 1. With req_ale_low=0 the active level is 1; with req_ale_low=1 the active level is 0.
- R3: For every cycle in which rd_n is 0, ad_oe_lo is 0 and the low byte is released. In the same cycles ad_oe_hi is 1 and ad_out[15:8] equals the request address bits 15:8.
- R4: rd_n stays low for max(req_dur,1) peripheral clocks, which is 2*max(req_dur,1) core cycles. A duration of 0 therefore gives one peripheral clock.
- R5: With req_flash=1, 7 peripheral clocks are inserted between the ALE recovery and the strobe. With req_flash=0, none are inserted.
- R6: With req_hold=1, one peripheral clock is inserted after rd_n rises and before the turnaround. With req_hold=0, none is inserted.
- R7: ad_in is captured at the core clock edge at which rd_n rises, and that byte is presented on rdata while done is 1.
- R8: done is a one-cycle pulse. It appears 2*(4+F+max(req_dur,1)+H) core cycles after the accepting edge, where F is 7 or 0 and H is 1 or 0. The block is idle again in the same cycle.
- R9: A req_valid that arrives while a read is in progress is ignored. The read in progress keeps its address and timing, and no extra done is produced.
- R10: In the last peripheral clock before done (the turnaround), rd_n is 1, ad_oe_lo is 1 and ad_out[7:0] equals the request address bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a read (taken only when idle) |
| req_addr | input | 16 | Read address |
| req_dur | input | 5 | Strobe duration in peripheral clocks (0 acts as 1) |
| req_hold | input | 1 | Insert one hold period after the strobe |
| req_flash | input | 1 | Insert seven wait periods before the strobe |
| req_ale_low | input | 1 | 1 selects active-low ALE |
| ad_in | input | 8 | Data sampled from the low byte of the bus |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| ad_out | output | 16 | Value driven onto the bus |
| ad_oe_lo | output | 1 | Drive enable for bus bits 7:0 |
| ad_oe_hi | output | 1 | Drive enable for bus bits 15:8 |
| rdata | output | 8 | Captured read data |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every result is tied to the accepting edge. done and rdata are due 2*(4+F+max(D,1)+H) core cycles after that edge. ALE must stay active for 4 cycles and rd_n low for 2*max(D,1) cycles. The turnaround values must be present in the sample just before done, and done must be low again in the next sample. The driver records the expected accepting-edge index from a free-running cycle counter. The monitor samples on falling edges only, compares the measured widths and latency against numbers it derives from the request fields, and treats a done with nothing pending as a miscompare. That rule is what catches a busy-time request that was wrongly accepted. The bench memory returns its data only while rd_n is low, so a capture taken one edge late reads a wrong byte.

// File: rtl/pp_rd_pkg.sv
package pp_rd_pkg;
  localparam int PP_DUR_W       = 5;
  localparam int PP_ALE_PCLKS   = 2;
  localparam int PP_FLASH_PCLKS = 7;
  localparam int PP_CNT_W       = PP_DUR_W + 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ALE, ST_ALE_REC, ST_FLASH, ST_READ, ST_HOLD, ST_TURN
  } pp_state_e;

  typedef struct packed {
    logic [PP_DUR_W-1:0] dur;
    logic                hold;
    logic                flash;
    logic                ale_low;
  } pp_cfg_t;

  // strobe length in peripheral clocks; zero is promoted to one
  function automatic logic [PP_CNT_W-1:0] eff_dur(input logic [PP_DUR_W-1:0] d);
    if (d == '0) return PP_CNT_W'(1);
    return PP_CNT_W'(d);
  endfunction

  // length of a phase in peripheral clocks
  function automatic logic [PP_CNT_W-1:0] phase_len(input pp_state_e st, input pp_cfg_t c);
    case (st)
      ST_ALE:   return PP_CNT_W'(PP_ALE_PCLKS);
      ST_FLASH: return PP_CNT_W'(PP_FLASH_PCLKS);
      ST_READ:  return eff_dur(c.dur);
      default:  return PP_CNT_W'(1);
    endcase
  endfunction

  // phase order with optional phases skipped
  function automatic pp_state_e next_phase(input pp_state_e st, input pp_cfg_t c);
    case (st)
      ST_IDLE:    return ST_ALE;
      ST_ALE:     return ST_ALE_REC;
      ST_ALE_REC: return c.flash ? ST_FLASH : ST_READ;
      ST_FLASH:   return ST_READ;
      ST_READ:    return c.hold ? ST_HOLD : ST_TURN;
      ST_HOLD:    return ST_TURN;
      default:    return ST_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/pp_pclk_tick.sv
module pp_pclk_tick #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic pce
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] div_cnt;

  assign pce = run && (div_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          div_cnt <= '0;
    else if (!run)       div_cnt <= '0;
    else if (pce)        div_cnt <= '0;
    else                 div_cnt <= div_cnt + CW'(1);
  end

  AST_TICK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !pce);
endmodule

// File: rtl/pp_rd_fsm.sv
module pp_rd_fsm
  import pp_rd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      pce,
  input  pp_cfg_t   cfg,
  output pp_state_e state,
  output logic      rd_rise,
  output logic      done
);
  logic [PP_CNT_W-1:0] cnt;
  pp_state_e           nxt_st;
  logic                phase_end;

  assign nxt_st    = next_phase(state, cfg);
  assign phase_end = (state != ST_IDLE) && pce && (cnt == '0);
  assign rd_rise   = phase_end && (state == ST_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == ST_IDLE) begin
        if (start) begin
          state <= ST_ALE;
          cnt   <= phase_len(ST_ALE, cfg) - PP_CNT_W'(1);
        end
      end else if (phase_end) begin
        state <= nxt_st;
        cnt   <= phase_len(nxt_st, cfg) - PP_CNT_W'(1);
        if (state == ST_TURN) done <= 1'b1;
      end else if (pce) begin
        cnt <= cnt - PP_CNT_W'(1);
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                         // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> state == ST_IDLE);                              // R8
  AST_NO_HOLD_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise && cfg.hold) |=> state == ST_HOLD);             // R6
endmodule

// File: rtl/pp_rd_capture.sv
module pp_rd_capture #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (cap) q <= d;
  end

  AST_CAPTURE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> q == $past(d));                                  // R7
endmodule

// File: rtl/pp_rd_seq.sv
module pp_rd_seq
  import pp_rd_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 8,
  parameter int DIV = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [AW-1:0]       req_addr,
  input  logic [PP_DUR_W-1:0] req_dur,
  input  logic                req_hold,
  input  logic                req_flash,
  input  logic                req_ale_low,
  input  logic [DW-1:0]       ad_in,
  output logic                ale,
  output logic                rd_n,
  output logic [AW-1:0]       ad_out,
  output logic                ad_oe_lo,
  output logic                ad_oe_hi,
  output logic [DW-1:0]       rdata,
  output logic                done
);
  localparam int ALE_CYC = PP_ALE_PCLKS * DIV;
  localparam int RUN_W   = $clog2(ALE_CYC + 2) + 1;

  pp_state_e     state;
  pp_cfg_t       cfg_q;
  pp_cfg_t       cfg_sel;
  logic [AW-1:0] addr_q;
  logic          idle, accept, pce, rd_rise, ale_act;
  logic [RUN_W-1:0] ale_run;

  assign idle    = (state == ST_IDLE);
  assign accept  = req_valid && idle;
  assign cfg_sel = idle ? '{dur: req_dur, hold: req_hold, flash: req_flash,
                            ale_low: req_ale_low} : cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cfg_q  <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
      cfg_q  <= cfg_sel;
    end
  end

  pp_pclk_tick #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(!idle), .pce(pce)
  );

  pp_rd_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(accept), .pce(pce), .cfg(cfg_q),
    .state(state), .rd_rise(rd_rise), .done(done)
  );

  pp_rd_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap(rd_rise), .d(ad_in), .q(rdata)
  );

  assign ale_act  = (state == ST_ALE);
  assign ale      = ale_act ^ cfg_q.ale_low;
  assign rd_n     = (state != ST_READ);
  assign ad_oe_hi = !idle;
  assign ad_oe_lo = (state == ST_ALE) || (state == ST_TURN);
  assign ad_out   = idle ? '0 : addr_q;

  // run length of the ALE pulse, for the width check only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ale_run <= '0;
    else if (ale_act) ale_run <= ale_run + RUN_W'(1);
    else              ale_run <= '0;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (rd_n && !ad_oe_lo && !ad_oe_hi));              // R1
  AST_ALE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale_act) |-> ale_run == RUN_W'(ALE_CYC));          // R2
  AST_LO_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (!ad_oe_lo && ad_oe_hi && !ale_act));          // R3
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && req_valid) |=> $stable(addr_q));               // R9
  AST_TURN_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(ad_oe_lo && rd_n));                       // R10
endmodule

// File: tb/sim_pp_rd_seq.sv
module sim_pp_rd_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic [4:0]  req_dur = '0;
  logic        req_hold = 1'b0, req_flash = 1'b0, req_ale_low = 1'b0;
  logic [7:0]  ad_in;
  logic        ale, rd_n, ad_oe_lo, ad_oe_hi, done;
  logic [15:0] ad_out;
  logic [7:0]  rdata;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  bit finished = 0;

  typedef struct {
    logic [15:0] addr; logic pol; int acc; int rd_w; int total; logic [7:0] data;
  } exp_t;
  exp_t q[$];

  pp_rd_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_dur(req_dur), .req_hold(req_hold), .req_flash(req_flash),
    .req_ale_low(req_ale_low), .ad_in(ad_in), .ale(ale), .rd_n(rd_n),
    .ad_out(ad_out), .ad_oe_lo(ad_oe_lo), .ad_oe_hi(ad_oe_hi),
    .rdata(rdata), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // bench memory: latches the address during ALE, drives data only under RD
  logic [15:0] lat_addr = '0;
  logic        cur_pol = 1'b0;
  always @(negedge clk) if (ale ^ cur_pol) lat_addr <= ad_out;
  assign ad_in = !rd_n ? mem_f(lat_addr) : 8'hEE;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [15:0] a, input logic [4:0] d, input logic h,
                         input logic f, input logic p, input bit poke);
    exp_t e;
    int dd;
    wait (q.size() == 0);
    @(negedge clk);
    dd = (d == 0) ? 1 : int'(d);
    e.addr = a; e.pol = p; e.acc = cyc + 1; e.rd_w = 2 * dd;
    e.total = 2 * (4 + (f ? 7 : 0) + dd + (h ? 1 : 0));
    e.data = mem_f(a);
    req_addr = a; req_dur = d; req_hold = h; req_flash = f; req_ale_low = p;
    cur_pol = p; req_valid = 1'b1;
    q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      req_addr = ~a; req_dur = 5'd9; req_valid = 1'b1;   // R9 busy request
      @(negedge clk);
      req_valid = 1'b0; req_addr = a;
    end
  endtask

  // monitor / scoreboard
  int ale_cnt = 0, rd_cnt = 0;
  bit bad_bus = 0, chk_low = 0;
  logic p_oe_lo = 0, p_rd = 1;
  logic [7:0] p_lo = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (chk_low) begin
        check(done == 1'b0, "R8 done one cycle", int'(done), 0);
        chk_low = 0;
      end
      if (q.size() > 0 && cyc >= q[0].acc) begin
        if (ale ^ q[0].pol) ale_cnt++;
        if (!rd_n) begin
          rd_cnt++;
          if (ad_oe_lo || !ad_oe_hi || ad_out[15:8] != q[0].addr[15:8]) bad_bus = 1;
        end
        if (done) begin
          check(rdata == q[0].data, "R7 rdata", int'(rdata), int'(q[0].data));
          check(cyc - q[0].acc == q[0].total, "R8/R5/R6 latency",
                cyc - q[0].acc, q[0].total);
          check(ale_cnt == 4, "R2 ALE width", ale_cnt, 4);
          check(rd_cnt == q[0].rd_w, "R4 RD width", rd_cnt, q[0].rd_w);
          check(!bad_bus, "R3 bus during RD", int'(bad_bus), 0);
          check(p_oe_lo && p_rd && p_lo == q[0].addr[7:0], "R10 turnaround",
                int'(p_lo), int'(q[0].addr[7:0]));
          check(ale == q[0].pol && rd_n, "R1 idle after done", int'(ale), int'(q[0].pol));
          void'(q.pop_front());
          ale_cnt = 0; rd_cnt = 0; bad_bus = 0; chk_low = 1;
        end else begin
          p_oe_lo = ad_oe_lo; p_rd = rd_n; p_lo = ad_out[7:0];
        end
      end else if (done) begin
        check(0, "R9 unexpected done", 1, 0);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ale == 0 && rd_n == 1 && !ad_oe_lo && !ad_oe_hi && !done,
          "R1 reset outputs", int'({ale, rd_n, ad_oe_lo, ad_oe_hi, done}), 5'b01000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    do_read(16'h1234, 5'd3,  0, 0, 0, 0);
    do_read(16'hA5C3, 5'd0,  0, 0, 0, 0);   // R4 zero duration
    do_read(16'hFFFF, 5'd31, 0, 0, 0, 0);   // R4 maximum
    do_read(16'h0F0F, 5'd2,  1, 0, 0, 0);   // R6
    do_read(16'h8001, 5'd1,  0, 1, 0, 0);   // R5
    do_read(16'h3C96, 5'd5,  1, 1, 1, 0);   // R2 active-low, R5, R6
    do_read(16'h7E11, 5'd4,  0, 0, 1, 1);   // R9
    do_read(16'h2468, 5'd2,  1, 0, 0, 0);   // back-to-back after done
    wait (q.size() == 0);
    repeat (40) @(negedge clk);
    check(done == 0 && rd_n == 1 && !ad_oe_hi, "R9 no extra cycle", int'(done), 0);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule